// File: doc/BRIEF.md
# Diagnostic output selector with PLL-bypass dividers

This block drives a single-ended diagnostic pin and the main clock output of a clock synthesizer. A 3-bit select code chooses what the diagnostic pin shows. The choices are the last stage of the 12-bit serial configuration shift register, a constant high or low, the reference clock divided by two, the M feedback counter pulse, the main output, and the main output divided by four. One code puts the block into PLL-bypass mode. In that mode the M and N dividers are clocked from the serial clock instead of the PLL-side clock. The N divider then produces the main output and the M counter drives the diagnostic pin.

All logic runs on one fast system clock. Each slow clock reaches the block as a one-cycle advance pulse: the serial clock, the reference clock, and a stand-in for the VCO-side clock. Outputs are registered levels, or a mux over registered levels. The N post divider divides by 2N, where N is the 2-bit N setting plus one, so the main output is never faster than half its source. The M counter gives a high level lasting one source period at the end of every M source periods; an M setting of zero behaves as one. Any change of the select code restarts the dividers.

Top module: `test_out_mux`

## Requirements
- R1: While reset is high and in the first cycle after it, test_out and fout are 0 (select code 000 with an empty shift register).
- R2: Code 000 shows the last stage of a 12-bit shift register that takes ser_din on each ser_tick, so after k ticks (k >= 12) test_out equals the bit shifted in at tick k-11; before that it is 0.
- R3: Code 001 drives test_out to 1 and code 101 drives it to 0.
- R4: Code 010 shows a flop that toggles on every ref_tick, starting at 0 after reset.
- R5: Outside bypass, after j vco_ticks counted from a restart, fout equals floor(j/N) mod 2 with N = n_sel + 1, and ser_tick has no effect on fout.
- R6: After j source ticks from a restart the M pulse is high exactly when j mod M equals M-1, with M = m_val, and m_val = 0 treated as 1; code 011 shows it on test_out.
- R7: Code 100 shows fout on test_out.
- R8: Code 111 shows fout divided by 4: test_out equals floor(j/(4N)) mod 2.
- R9: Code 110 (bypass) counts ser_tick instead of vco_tick in both dividers, ignores vco_tick, and shows the M pulse on test_out.
- R10: In the cycle after any change of the select code, fout and the divide-by-4 output are 0 and the N and M counters start over from their reload values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 3 | Diagnostic select code |
| m_val | input | 7 | Latched M divide value |
| n_sel | input | 2 | Latched N setting, ratio 2*(n_sel+1) |
| ser_tick | input | 1 | Serial clock advance pulse |
| ser_din | input | 1 | Serial data into the shift register |
| ref_tick | input | 1 | Reference clock advance pulse |
| vco_tick | input | 1 | PLL-side clock advance pulse |
| test_out | output | 1 | Diagnostic output |
| fout | output | 1 | Main clock output |

## Verification
The dividers are swept over every N setting and the M values 0, 1, 2, 3 and 5 under codes 011, 100, 111 and 110. Each run starts from a forced code change and steps the source pulse on alternate cycles. The other clock pulse is held high the whole time, so a design that counts the wrong source gets the periods wrong. The sweep tells the phase of fout, the phase of the M pulse and the divide-by-4 ratio apart for each setting. Separate passes shift a known 24-bit pattern through code 000, toggle the reference under code 010, check both constant codes, and switch codes mid-count to show the restart.

// File: rtl/test_out_mux.sv
module test_out_mux #(
  parameter int MW  = 7,
  parameter int NW  = 2,
  parameter int SRW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sel,
  input  logic [MW-1:0] m_val,
  input  logic [NW-1:0] n_sel,
  input  logic          ser_tick,
  input  logic          ser_din,
  input  logic          ref_tick,
  input  logic          vco_tick,
  output logic          test_out,
  output logic          fout
);

  localparam logic [2:0] C_SHIFT  = 3'b000;
  localparam logic [2:0] C_ONE    = 3'b001;
  localparam logic [2:0] C_REF2   = 3'b010;
  localparam logic [2:0] C_MCNT   = 3'b011;
  localparam logic [2:0] C_FOUT   = 3'b100;
  localparam logic [2:0] C_ZERO   = 3'b101;
  localparam logic [2:0] C_BYPASS = 3'b110;
  localparam logic [2:0] C_FOUT4  = 3'b111;

  logic [SRW-1:0] sreg;
  logic           ref_div;
  logic [2:0]     sel_q;
  logic [MW-1:0]  m_cnt;
  logic [NW-1:0]  n_cnt;
  logic [2:0]     t_cnt;

  wire           bypass  = (sel == C_BYPASS);
  wire           src     = bypass ? ser_tick : vco_tick;
  wire           restart = (sel != sel_q);
  wire [MW-1:0]  mload   = (m_val == '0) ? '0 : m_val - 1'b1;
  wire           m_out   = (m_cnt == '0);
  wire           n_wrap  = (n_cnt == n_sel);
  wire           fdiv4   = t_cnt[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg    <= '0;
      ref_div <= 1'b0;
      sel_q   <= C_SHIFT;
    end else begin
      sel_q <= sel;
      if (ser_tick) sreg <= {sreg[SRW-2:0], ser_din};
      if (ref_tick) ref_div <= ~ref_div;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      m_cnt <= mload;
      n_cnt <= '0;
      fout  <= 1'b0;
      t_cnt <= '0;
    end else if (src) begin
      m_cnt <= m_out ? mload : m_cnt - 1'b1;
      n_cnt <= n_wrap ? '0 : n_cnt + 1'b1;
      if (n_wrap) begin
        fout  <= ~fout;
        t_cnt <= t_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      C_SHIFT:  test_out = sreg[SRW-1];
      C_ONE:    test_out = 1'b1;
      C_REF2:   test_out = ref_div;
      C_MCNT:   test_out = m_out;
      C_FOUT:   test_out = fout;
      C_ZERO:   test_out = 1'b0;
      C_BYPASS: test_out = m_out;
      default:  test_out = fdiv4;
    endcase
  end

  AST_FOUT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(fout) |-> $past(src) || $past(restart)); // R5

  AST_BYPASS_IGNORES_VCO: assert property (@(posedge clk) disable iff (rst)
    (bypass && !restart && !ser_tick) |=> $stable(fout) && $stable(m_cnt)); // R9

  AST_REF_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> ref_div != $past(ref_div)); // R4

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> !fout && !fdiv4 && n_cnt == '0); // R10

  AST_M_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (m_out && src && !restart && mload != '0 && sel == $past(sel)) |=> !m_out); // R6

  AST_DIV4_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$stable(fdiv4) |-> !$stable(fout) || $past(restart)); // R8

endmodule

// File: tb/test_out_mux_tb.sv
module test_out_mux_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] sel = 3'b000;
  logic [6:0] m_val = 7'd1;
  logic [1:0] n_sel = 2'd0;
  logic ser_tick = 1'b0, ser_din = 1'b0, ref_tick = 1'b0, vco_tick = 1'b0;
  logic test_out, fout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  test_out_mux dut_i (.clk(clk), .rst(rst), .sel(sel), .m_val(m_val), .n_sel(n_sel),
    .ser_tick(ser_tick), .ser_din(ser_din), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .test_out(test_out), .fout(fout));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart_to(input logic [2:0] code);
    ser_tick = 0; vco_tick = 0; ref_tick = 0;
    sel = code ^ 3'b001; cyc();
    sel = code; cyc();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] pat;
    int mlist [5] = '{0, 1, 2, 3, 5};
    logic [2:0] dcodes [4] = '{3'b011, 3'b100, 3'b111, 3'b110};
    @(negedge clk);
    chk("R1 reset test_out", test_out, 1'b0);
    chk("R1 reset fout", fout, 1'b0);
    cyc(); cyc();
    rst = 0; cyc();
    chk("R1 after reset test_out", test_out, 1'b0);
    chk("R1 after reset fout", fout, 1'b0);

    // R2: shift register on code 000
    pat = 24'hB5_3C_96;
    for (int k = 1; k <= 24; k++) begin
      ser_din = pat[k-1]; ser_tick = 1; cyc();
      chk("R2 shift stage", test_out, (k >= 12) ? pat[k-12] : 1'b0);
    end
    ser_tick = 0; cyc();
    chk("R2 hold without tick", test_out, pat[12]);

    // R3
    sel = 3'b001; cyc(); chk("R3 const one", test_out, 1'b1);
    sel = 3'b101; cyc(); chk("R3 const zero", test_out, 1'b0);

    // R4
    sel = 3'b010; cyc();
    chk("R4 ref div start", test_out, 1'b0);
    for (int k = 1; k <= 9; k++) begin
      ref_tick = 1; cyc(); ref_tick = 0;
      chk("R4 ref div toggle", test_out, k[0]);
      cyc();
      chk("R4 ref div hold", test_out, k[0]);
    end

    // R5..R9 sweep
    foreach (dcodes[c]) begin
      for (int n = 0; n < 4; n++) begin
        foreach (mlist[mi]) begin
          int nn, mm, j;
          logic ef, et;
          bit byp;
          byp = (dcodes[c] == 3'b110);
          nn = n + 1;
          mm = (mlist[mi] == 0) ? 1 : mlist[mi];
          n_sel = n[1:0]; m_val = mlist[mi][6:0];
          restart_to(dcodes[c]);
          j = 0;
          for (int s = 0; s < 40; s++) begin
            ef = ((j / nn) % 2) == 1;
            case (dcodes[c])
              3'b100: et = ef;
              3'b111: et = ((j / (4 * nn)) % 2) == 1;
              default: et = (j % mm) == (mm - 1);
            endcase
            chk(byp ? "R9 bypass fout" : "R5 fout divide", fout, ef);
            case (dcodes[c])
              3'b011: chk("R6 M pulse", test_out, et);
              3'b100: chk("R7 fout on pin", test_out, et);
              3'b111: chk("R8 fout div4", test_out, et);
              default: chk("R9 bypass M pulse", test_out, et);
            endcase
            if (byp) begin ser_tick = s[0]; vco_tick = 1; end
            else begin vco_tick = s[0]; ser_tick = 1; end
            cyc();
            if (s[0]) j++;
          end
        end
      end
    end

    // R10: mid-count change
    n_sel = 2'd1; m_val = 7'd3;
    restart_to(3'b011);
    vco_tick = 1; cyc(); cyc(); cyc(); vco_tick = 0;
    chk("R10 pre-switch fout", fout, 1'b1);
    sel = 3'b100; cyc();
    chk("R10 fout cleared", fout, 1'b0);
    chk("R10 pin cleared", test_out, 1'b0);
    vco_tick = 1; cyc();
    chk("R10 count restarted 1", fout, 1'b0);
    cyc();
    chk("R10 count restarted 2", fout, 1'b1);
    vco_tick = 0;
    sel = 3'b011; cyc();
    chk("R10 M reloaded", test_out, 1'b0);
    vco_tick = 1; cyc(); cyc(); vco_tick = 0;
    chk("R10 M pulse after reload", test_out, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule